// File: doc/BRIEF.md
# Three-Phase Voltage Dip and Swell Monitor

This block watches the half-cycle RMS voltage of three phases. Each phase delivers a new value together with a one-cycle valid strobe. For every phase, two trackers run side by side:

- a dip tracker, which looks for values strictly under a low threshold;
- a swell tracker, which looks for values strictly over a high threshold.

A tracker enters its event state once a programmed number of consecutive qualifying samples has arrived. It leaves that state after the same number of consecutive non-qualifying samples.

While a tracker works, it keeps the extreme value seen: the minimum for a dip, the maximum for a swell. On entry to an event it sets a sticky status bit. It raises interrupt pulses according to a mode bit, which selects either periodic interrupts or one interrupt on entry and one on exit. A masked level output stays high for as long as any selected tracker is in its event state, so an external timer can measure the event's length.

The block sits directly after an RMS engine. Software or a host block supplies the thresholds, the cycle counts, the mode and the mask bits, and clears status through write-one-to-clear strobes.

Top module: `dipswell_mon`

## Requirements
- R1: A tracker enters its event state on the Nth consecutive valid sample beyond its threshold, where N is the programmed count. Beyond means strictly less than `dip_thr` for a dip, and strictly greater than `swl_thr` for a swell. A count of 0 behaves as 1.
- R2: A valid sample that is not beyond the threshold resets the run of beyond samples to zero. A cycle without that phase's valid bit changes nothing in that phase's trackers.
- R3: The bits of `sts` are ordered as follows: bits 0, 1 and 2 are dip on phases A, B and C; bits 3, 4 and 5 are swell on phases A, B and C. A bit becomes 1 on the clock edge where its tracker enters an event and stays 1 until a 1 arrives on the same bit of `sts_clr`. If a set and a clear fall on the same edge, the set wins. All bits are 0 after reset.
- R4: Phase p occupies bits [p*W+W-1 : p*W] of `dip_val` and of `swl_val`. The first beyond sample of a run that starts outside an event is loaded directly into the register. Every later beyond sample updates the register if it is lower (for `dip_val`) or higher (for `swl_val`).
- R5: While a tracker is in its event state, N consecutive valid samples that are not beyond the threshold end the event. A beyond sample among them restarts that count.
- R6: With `irq_mode` = 0, a tracker pulses its interrupt each time its run of beyond samples reaches N. This covers both entry and every further N beyond samples inside the event. The run then restarts at zero.
- R7: With `irq_mode` = 1, a tracker pulses exactly once on entry and exactly once on exit, and at no other time.
- R8: When N is 1 (or 0), exit also pulses the interrupt in mode 0, and the exiting, non-beyond sample is written into that phase's value register.
- R9: `irq_dip` is the OR over the phases of the dip pulses gated by `irq_en[p]`. `irq_swl` is the same for the swell pulses, gated by `irq_en[3+p]`. Each pulse is one cycle long and is high in the cycle after the clock edge that took the sample.
- R10: `evt_o` is high while any tracker is in its event state with its `evt_mask` bit set. The mask uses the same bit order as `sts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_vld | input | 3 | Per-phase valid strobe for a new RMS value |
| smp_val | input | 3*W | Per-phase RMS values, phase A in the low W bits |
| dip_thr | input | W | Dip threshold |
| swl_thr | input | W | Swell threshold |
| dip_ncyc | input | CW | Consecutive sample count for dips |
| swl_ncyc | input | CW | Consecutive sample count for swells |
| irq_mode | input | 1 | 0 = periodic interrupts, 1 = interrupts on entry and exit |
| irq_en | input | 6 | Interrupt enables, same order as sts |
| evt_mask | input | 6 | Event output enables, same order as sts |
| sts_clr | input | 6 | Write-one-to-clear strobes for sts |
| sts | output | 6 | Sticky dip and swell flags |
| dip_val | output | 3*W | Per-phase minimum during a dip |
| swl_val | output | 3*W | Per-phase maximum during a swell |
| irq_dip | output | 1 | Dip interrupt pulse |
| irq_swl | output | 1 | Swell interrupt pulse |
| evt_o | output | 1 | Masked event level |

## Verification
The assertions assume the following about the inputs:
- the mode bit is sampled as it was on the edge that produced a pulse;
- the thresholds may change at any time, because each check compares against the values present on the edge in question;
- the valid strobes are clean, defined values while reset is not active.

The stimulus drives inputs only on falling edges. It keeps each phase in a low, middle or high band for several samples at a time, so that runs of every length occur. It sometimes places a value exactly on a threshold. It changes the mode and the counts only between segments, and it varies them widely: counts 0 and 1, the entry and exit pulses, and the overwrite on exit all come up.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int PHASES = 3;
  typedef enum logic {TRK_DIP = 1'b0, TRK_SWELL = 1'b1} trk_kind_e;
endpackage

// File: rtl/ds_track.sv
module ds_track
  import ds_pkg::*;
#(
  parameter int        W    = 24,
  parameter int        CW   = 16,
  parameter trk_kind_e KIND = TRK_DIP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [W-1:0]  val_i,
  input  logic [W-1:0]  thr_i,
  input  logic [CW-1:0] ncyc_i,
  input  logic          mode_i,
  output logic          act_o,
  output logic          irq_o,
  output logic          set_o,
  output logic [W-1:0]  xval_o
);
  logic [CW-1:0] run_in_q, run_in_d, run_out_q, run_out_d;
  logic          act_q, act_d, irq_q, irq_d, set_d;
  logic [W-1:0]  xval_q, xval_d;
  logic          beyond, better, one, in_done, out_done;

  always_comb begin
    beyond   = (KIND == TRK_SWELL) ? (val_i > thr_i)  : (val_i < thr_i);
    better   = (KIND == TRK_SWELL) ? (val_i > xval_q) : (val_i < xval_q);
    one      = (ncyc_i <= {{(CW-1){1'b0}}, 1'b1});
    in_done  = (({1'b0, run_in_q}  + 1'b1) >= {1'b0, ncyc_i});
    out_done = (({1'b0, run_out_q} + 1'b1) >= {1'b0, ncyc_i});
  end

  always_comb begin
    run_in_d  = run_in_q;
    run_out_d = run_out_q;
    act_d     = act_q;
    xval_d    = xval_q;
    irq_d     = 1'b0;
    set_d     = 1'b0;
    if (vld_i) begin
      if (beyond) begin
        run_out_d = '0;
        if (!act_q && (run_in_q == '0)) xval_d = val_i;
        else if (better)                xval_d = val_i;
        if (in_done) begin
          run_in_d = '0;
          if (!act_q) begin
            act_d = 1'b1;
            set_d = 1'b1;
            irq_d = 1'b1;
          end else if (!mode_i) begin
            irq_d = 1'b1;
          end
        end else begin
          run_in_d = run_in_q + 1'b1;
        end
      end else begin
        run_in_d = '0;
        if (act_q) begin
          if (out_done) begin
            run_out_d = '0;
            act_d     = 1'b0;
            if (mode_i || one) irq_d = 1'b1;
            if (one)           xval_d = val_i;
          end else begin
            run_out_d = run_out_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_in_q  <= '0;
      run_out_q <= '0;
      act_q     <= 1'b0;
      irq_q     <= 1'b0;
      xval_q    <= '0;
    end else begin
      irq_q <= irq_d;
      if (vld_i) begin
        run_in_q  <= run_in_d;
        run_out_q <= run_out_d;
        act_q     <= act_d;
        xval_q    <= xval_d;
      end
    end
  end

  assign act_o  = act_q;
  assign irq_o  = irq_q;
  assign set_o  = set_d;
  assign xval_o = xval_q;

  // R1: an event starts only on a valid, beyond-threshold sample
  p_entry_on_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(vld_i) && $past(beyond)));

  // R7: in entry/exit mode a pulse always marks a state change
  p_mode1_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && $past(mode_i)) |-> (act_q != $past(act_q)));

  // R4: within a continuing event the extreme only moves outward
  p_extreme_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |->
      ((KIND == TRK_SWELL) ? (xval_q >= $past(xval_q)) : (xval_q <= $past(xval_q))));

  // R2: nothing moves without a strobe
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vld_i) |-> ($stable(act_q) && $stable(xval_q) && !irq_q));
endmodule

// File: rtl/ds_phase.sv
module ds_phase
  import ds_pkg::*;
#(
  parameter int W  = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [W-1:0]  val_i,
  input  logic [W-1:0]  dip_thr_i,
  input  logic [W-1:0]  swl_thr_i,
  input  logic [CW-1:0] dip_ncyc_i,
  input  logic [CW-1:0] swl_ncyc_i,
  input  logic          mode_i,
  output logic [1:0]    act_o,
  output logic [1:0]    irq_o,
  output logic [1:0]    set_o,
  output logic [W-1:0]  dip_val_o,
  output logic [W-1:0]  swl_val_o
);
  ds_track #(.W(W), .CW(CW), .KIND(TRK_DIP)) u_dip (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .val_i(val_i),
    .thr_i(dip_thr_i), .ncyc_i(dip_ncyc_i), .mode_i(mode_i),
    .act_o(act_o[0]), .irq_o(irq_o[0]), .set_o(set_o[0]), .xval_o(dip_val_o)
  );

  ds_track #(.W(W), .CW(CW), .KIND(TRK_SWELL)) u_swl (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .val_i(val_i),
    .thr_i(swl_thr_i), .ncyc_i(swl_ncyc_i), .mode_i(mode_i),
    .act_o(act_o[1]), .irq_o(irq_o[1]), .set_o(set_o[1]), .xval_o(swl_val_o)
  );
endmodule

// File: rtl/ds_combine.sv
module ds_combine #(
  parameter int NPH = 3,
  localparam int NT = 2 * NPH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] act_i,
  input  logic [NT-1:0] irq_i,
  input  logic [NT-1:0] set_i,
  input  logic [NT-1:0] clr_i,
  input  logic [NT-1:0] en_i,
  input  logic [NT-1:0] mask_i,
  output logic [NT-1:0] sts_o,
  output logic          irq_dip_o,
  output logic          irq_swl_o,
  output logic          evt_o
);
  logic [NT-1:0] sts_q, sts_d;
  logic [NT-1:0] irq_g;

  always_comb begin
    sts_d = (sts_q & ~clr_i) | set_i;
    irq_g = irq_i & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o     = sts_q;
  assign irq_dip_o = |irq_g[NPH-1:0];
  assign irq_swl_o = |irq_g[NT-1:NPH];
  assign evt_o     = |(act_i & mask_i);

  for (genvar i = 0; i < NT; i++) begin : g_chk
    // R3: a clear without a simultaneous set empties the flag
    p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !sts_q[i]);
    // R3: a set always lands
    p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> sts_q[i]);
  end
endmodule

// File: rtl/dipswell_mon.sv
module dipswell_mon
  import ds_pkg::*;
#(
  parameter int W  = 24,
  parameter int CW = 16,
  localparam int NPH = PHASES,
  localparam int NT  = 2 * NPH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPH-1:0]   smp_vld,
  input  logic [NPH*W-1:0] smp_val,
  input  logic [W-1:0]     dip_thr,
  input  logic [W-1:0]     swl_thr,
  input  logic [CW-1:0]    dip_ncyc,
  input  logic [CW-1:0]    swl_ncyc,
  input  logic             irq_mode,
  input  logic [NT-1:0]    irq_en,
  input  logic [NT-1:0]    evt_mask,
  input  logic [NT-1:0]    sts_clr,
  output logic [NT-1:0]    sts,
  output logic [NPH*W-1:0] dip_val,
  output logic [NPH*W-1:0] swl_val,
  output logic             irq_dip,
  output logic             irq_swl,
  output logic             evt_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [NT-1:0] act_v, irq_v, set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [1:0] act_l, irq_l, set_l;
    ds_phase #(.W(W), .CW(CW)) u_phase (
      .clk(clk), .rst_n(rst_n_s), .vld_i(smp_vld[p]),
      .val_i(smp_val[p*W +: W]),
      .dip_thr_i(dip_thr), .swl_thr_i(swl_thr),
      .dip_ncyc_i(dip_ncyc), .swl_ncyc_i(swl_ncyc), .mode_i(irq_mode),
      .act_o(act_l), .irq_o(irq_l), .set_o(set_l),
      .dip_val_o(dip_val[p*W +: W]), .swl_val_o(swl_val[p*W +: W])
    );
    assign act_v[p]       = act_l[0];
    assign act_v[NPH + p] = act_l[1];
    assign irq_v[p]       = irq_l[0];
    assign irq_v[NPH + p] = irq_l[1];
    assign set_v[p]       = set_l[0];
    assign set_v[NPH + p] = set_l[1];
  end

  ds_combine #(.NPH(NPH)) u_comb (
    .clk(clk), .rst_n(rst_n_s), .act_i(act_v), .irq_i(irq_v), .set_i(set_v),
    .clr_i(sts_clr), .en_i(irq_en), .mask_i(evt_mask),
    .sts_o(sts), .irq_dip_o(irq_dip), .irq_swl_o(irq_swl), .evt_o(evt_o)
  );
endmodule

// File: tb/dipswell_mon_test.sv
module dipswell_mon_test;
  localparam int W = 24;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    smp_vld = '0;
  logic [3*W-1:0] smp_val = '0;
  logic [W-1:0]  dip_thr = 24'd1000, swl_thr = 24'd2000;
  logic [CW-1:0] dip_ncyc = 16'd3, swl_ncyc = 16'd3;
  logic          irq_mode = 1'b0;
  logic [5:0]    irq_en = 6'h3f, evt_mask = 6'h3f, sts_clr = '0;
  logic [5:0]    sts;
  logic [3*W-1:0] dip_val, swl_val;
  logic          irq_dip, irq_swl, evt_o;

  int n_chk = 0, n_bad = 0;

  dipswell_mon #(.W(W), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_val(smp_val),
    .dip_thr(dip_thr), .swl_thr(swl_thr), .dip_ncyc(dip_ncyc), .swl_ncyc(swl_ncyc),
    .irq_mode(irq_mode), .irq_en(irq_en), .evt_mask(evt_mask), .sts_clr(sts_clr),
    .sts(sts), .dip_val(dip_val), .swl_val(swl_val),
    .irq_dip(irq_dip), .irq_swl(irq_swl), .evt_o(evt_o)
  );

  always #5 clk = ~clk;

  // reference model state, index t: 0..2 dip A..C, 3..5 swell A..C
  int unsigned m_in[6], m_out[6];
  bit          m_act[6], m_irq[6];
  logic [W-1:0] m_x[6];
  logic [5:0]  m_sts;

  task automatic chk(input string tag, input logic [3*W-1:0] act, input logic [3*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 6; t++) begin
      m_in[t] = 0; m_out[t] = 0; m_act[t] = 0; m_irq[t] = 0; m_x[t] = '0;
    end
    m_sts = '0;
  endtask

  task automatic model_step(input logic [2:0] v, input logic [3*W-1:0] vals, input logic [5:0] clr);
    logic [5:0] setv;
    setv = '0;
    for (int t = 0; t < 6; t++) begin
      int ph; bit sw, bey, one; int unsigned n; logic [W-1:0] x, thr;
      ph = t % 3; sw = (t >= 3);
      n = sw ? swl_ncyc : dip_ncyc;
      if (n == 0) n = 1;
      one = (n == 1);
      thr = sw ? swl_thr : dip_thr;
      m_irq[t] = 0;
      if (v[ph]) begin
        x = vals[ph*W +: W];
        bey = sw ? (x > thr) : (x < thr);
        if (bey) begin
          m_out[t] = 0;
          if (!m_act[t] && m_in[t] == 0) m_x[t] = x;
          else if (sw ? (x > m_x[t]) : (x < m_x[t])) m_x[t] = x;
          if (m_in[t] + 1 >= n) begin
            m_in[t] = 0;
            if (!m_act[t]) begin m_act[t] = 1; setv[t] = 1; m_irq[t] = 1; end
            else if (!irq_mode) m_irq[t] = 1;
          end else m_in[t]++;
        end else begin
          m_in[t] = 0;
          if (m_act[t]) begin
            if (m_out[t] + 1 >= n) begin
              m_out[t] = 0; m_act[t] = 0;
              if (irq_mode || one) m_irq[t] = 1;
              if (one) m_x[t] = x;
            end else m_out[t]++;
          end
        end
      end
    end
    m_sts = (m_sts & ~clr) | setv;
  endtask

  // one sample cycle: drive at falling edge, compare at the next falling edge
  task automatic step(input logic [2:0] v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] c, input logic [5:0] clr);
    logic [3*W-1:0] vals, ed, es;
    bit eid, eis, eev;
    vals = {c, b, a};
    smp_vld = v; smp_val = vals; sts_clr = clr;
    model_step(v, vals, clr);
    @(posedge clk);
    @(negedge clk);
    smp_vld = '0; sts_clr = '0;
    eid = 0; eis = 0; eev = 0;
    for (int t = 0; t < 6; t++) begin
      if (m_irq[t] && irq_en[t]) begin if (t < 3) eid = 1; else eis = 1; end
      if (m_act[t] && evt_mask[t]) eev = 1;
    end
    ed = {m_x[2], m_x[1], m_x[0]};
    es = {m_x[5], m_x[4], m_x[3]};
    chk("R3 sts", {66'd0, sts}, {66'd0, m_sts});
    chk("R4 dip_val", dip_val, ed);
    chk("R4 swl_val", swl_val, es);
    chk("R9 irq_dip", {71'd0, irq_dip}, {71'd0, eid});
    chk("R9 irq_swl", {71'd0, irq_swl}, {71'd0, eis});
    chk("R10 evt_o", {71'd0, evt_o}, {71'd0, eev});
  endtask

  function automatic logic [W-1:0] band(input int r);
    int unsigned k;
    k = $urandom % 16;
    if (k == 0) return (r == 2) ? swl_thr : dip_thr;
    case (r)
      0:       return 24'd700 + ($urandom % 300);
      1:       return 24'd1300 + ($urandom % 400);
      default: return 24'd2001 + ($urandom % 300);
    endcase
  endfunction

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rg[3];
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R3 reset sts", {66'd0, sts}, '0);
    chk("R4 reset dip_val", dip_val, '0);
    chk("R10 reset evt_o", {71'd0, evt_o}, '0);

    // directed: count 3, periodic mode, phase A dip
    step(3'b111, 900, 1500, 1500, 0);
    step(3'b111, 900, 1500, 1500, 0);
    step(3'b110, 0, 1500, 1500, 0);          // no strobe on A: ignored
    step(3'b111, 1000, 1500, 1500, 0);       // equal to threshold: not beyond
    step(3'b111, 900, 1500, 1500, 0);
    step(3'b111, 880, 1500, 1500, 0);
    chk("R2 run reset keeps dip A off", {71'd0, sts[0]}, 72'd0);
    step(3'b111, 950, 1500, 1500, 0);
    chk("R1 dip A entered on third sample", {71'd0, sts[0]}, 72'd1);
    chk("R6 entry pulse", {71'd0, irq_dip}, 72'd1);
    chk("R10 evt high in dip", {71'd0, evt_o}, 72'd1);
    chk("R4 min of run", {48'd0, dip_val[W-1:0]}, 72'd880);
    step(3'b111, 1500, 1500, 1500, 0);
    step(3'b111, 1500, 1500, 1500, 0);
    chk("R10 evt still high", {71'd0, evt_o}, 72'd1);
    step(3'b111, 1500, 1500, 1500, 0);
    chk("R5 exit after three", {71'd0, evt_o}, 72'd0);
    chk("R6 no exit pulse in mode 0", {71'd0, irq_dip}, 72'd0);
    step(3'b000, 0, 0, 0, 6'b000001);
    chk("R3 w1c clears", {71'd0, sts[0]}, 72'd0);

    // directed: count 1, mode 0
    dip_ncyc = 16'd1;
    step(3'b001, 800, 0, 0, 0);
    chk("R6 count 1 entry", {71'd0, irq_dip}, 72'd1);
    step(3'b001, 1200, 0, 0, 0);
    chk("R8 exit pulse", {71'd0, irq_dip}, 72'd1);
    chk("R8 exit sample stored", {48'd0, dip_val[W-1:0]}, 72'd1200);
    irq_en = 6'b111110;
    step(3'b001, 800, 0, 0, 0);
    chk("R9 gated pulse", {71'd0, irq_dip}, 72'd0);
    step(3'b001, 1200, 0, 0, 0);
    irq_en = 6'h3f;

    // directed: entry/exit mode, swell on phase B, count 2
    irq_mode = 1'b1; swl_ncyc = 16'd2;
    step(3'b010, 0, 2500, 0, 0);
    step(3'b010, 0, 2600, 0, 0);
    chk("R7 entry pulse", {71'd0, irq_swl}, 72'd1);
    step(3'b010, 0, 2700, 0, 0);
    step(3'b010, 0, 2650, 0, 0);
    chk("R7 no periodic pulse", {71'd0, irq_swl}, 72'd0);
    chk("R4 swell max", {48'd0, swl_val[2*W-1:W]}, 72'd2700);
    step(3'b010, 0, 1500, 0, 0);
    step(3'b010, 0, 1500, 0, 0);
    chk("R7 exit pulse", {71'd0, irq_swl}, 72'd1);
    step(3'b010, 0, 2300, 0, 0);
    chk("R4 reload on new run", {48'd0, swl_val[2*W-1:W]}, 72'd2300);
    step(3'b010, 0, 1500, 0, 0);

    // random segments
    for (int i = 0; i < 3; i++) rg[i] = 1;
    for (int seg = 0; seg < 8; seg++) begin
      irq_mode = seg[0];
      dip_ncyc = (seg < 2) ? 16'd1 : 16'($urandom % 6);
      swl_ncyc = (seg < 2) ? 16'd1 : 16'($urandom % 6);
      irq_en   = 6'($urandom);
      evt_mask = 6'($urandom);
      for (int k = 0; k < 500; k++) begin
        logic [2:0] v;
        logic [5:0] clr;
        for (int i = 0; i < 3; i++) if ($urandom % 8 == 0) rg[i] = $urandom % 3;
        v = 3'($urandom) | 3'($urandom);
        clr = ($urandom % 10 == 0) ? 6'($urandom) : 6'd0;
        step(v, band(rg[0]), band(rg[1]), band(rg[2]), clr);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule